// File: doc/BRIEF.md
# Bus Ownership Handover Controller

This block decides when a processor core gives up its 16-bit-address, 8-bit-data bus to an outside master such as a DMA engine. The outside master pulls an active-low request line. The line is wired-OR on the board with an external pull-up. The block re-times that line through a synchroniser. It hands the bus over only on a clock edge where the core marks the end of a machine cycle, so a cycle that is already in progress always completes.

Once it decides to hand over, the block drops the output enables of the address bus, the data bus and the four access strobes (memory request, I/O request, read, write). It also holds the core stalled. It drives the active-low acknowledge one cycle later, so the acknowledge only appears when those lines are already released. The status lines (opcode-fetch marker, halt, refresh) stay driven. When the request goes away, the bus is driven again one cycle before the core is allowed to continue. A saturating counter of consecutive granted cycles lets monitoring logic detect grants long enough to threaten memory refresh. A pending non-maskable interrupt loses to a bus request recognised at the same boundary.

Top module: `busHandover`

## Requirements
- R1: While reset is active: `ackN` is 1, `addrOe` is 1, `strobeOe` is 4'b1111, `dataOe` equals `coreDataDrive`, `coreStall` is 0 and `grantCount` is 0.
- R2: The request passes through a two-stage synchroniser. A low on `extReqN` first set up before clock edge n can be acted on no earlier than edge n+2, and only if `cycleEnd` is high at that edge.
- R3: While the bus is owned by the core and `cycleEnd` is low, a low `extReqN` leaves `addrOe`, `dataOe`, `strobeOe`, `ackN` and `coreStall` unchanged.
- R4: At an edge where `cycleEnd` is high and the synchronised request is active, the next cycle shows `addrOe`=0, `dataOe`=0, `strobeOe`=4'b0000 and `coreStall`=1, with `ackN` still 1.
- R5: `ackN` goes low exactly one cycle after the enables drop, and is low only while all bus and strobe enables are 0.
- R6: `nmiTake` is high in a cycle where the core owns the bus, is not stalled, and `cycleEnd` and `nmiPend` are both high. It is 0 when a synchronised request is active at that same boundary, and the bus is granted instead.
- R7: On the third edge after `extReqN` returns high, `ackN` rises and all enables return to 1 while `coreStall` stays 1. On the next edge `coreStall` falls to 0.
- R8: `coreStall` is 1 in every cycle in which `ackN` is 0.
- R9: `statusOe` stays 1 throughout a grant.
- R10: `grantCount` is cleared on the edge that starts a handover. It increases by one on every edge taken while `ackN` is low, stops at its all-ones maximum, and holds its value after release until the next handover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| extReqN | input | 1 | Asynchronous active-low bus request from the outside master |
| cycleEnd | input | 1 | Core marks the last clock of a machine cycle |
| nmiPend | input | 1 | Core has a non-maskable interrupt waiting |
| coreDataDrive | input | 1 | Core wants to drive the data bus in this cycle |
| addrOe | output | 1 | Output enable of the address bus |
| dataOe | output | 1 | Output enable of the data bus |
| strobeOe | output | 4 | Enables of memory request [3], I/O request [2], read [1], write [0] |
| statusOe | output | 1 | Enable of the fetch, halt and refresh status lines |
| ackN | output | 1 | Active-low bus grant acknowledge |
| coreStall | output | 1 | Holds the core between machine cycles |
| nmiTake | output | 1 | The waiting NMI is taken at this boundary |
| grantCount | output | CNT_W | Saturating count of consecutive granted cycles |

## Verification
The properties assume that the core raises `cycleEnd` only while it is not stalled. They also assume that the outside master keeps its request low until it sees the acknowledge, and keeps it high for at least two clocks after releasing it. The directed stimulus changes every input on the falling clock edge. It holds `cycleEnd` low for the whole of each grant, and it never toggles the request faster than the synchroniser can follow. This keeps the stimulus inside those assumptions. `coreDataDrive` is left high throughout the grants, so the stimulus shows that a core data request cannot re-enable the data bus while the bus is granted.

// File: rtl/busHandoverPkg.sv
package busHandoverPkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_FLOAT   = 2'd1,
    ST_GRANT   = 2'd2,
    ST_RELEASE = 2'd3
  } hoState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic floatBus;
    logic ackOn;
    logic stall;
    logic clearCnt;
    logic countEn;
  } hoStrobe_t;

endpackage

// File: rtl/busHandoverCtrl.sv
module busHandoverCtrl
  import busHandoverPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqActive,
  input  logic      cycleEnd,
  input  logic      nmiPend,
  output hoStrobe_t strobe,
  output logic      nmiTake
);

  hoState_t stateQ, stateD;
  logic     takeBus;

  // the handover is only decided on a machine-cycle boundary
  assign takeBus = (stateQ == ST_RUN) && cycleEnd && reqActive;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_RUN:     if (takeBus) stateD = ST_FLOAT;
      ST_FLOAT:   stateD = ST_GRANT;
      ST_GRANT:   if (!reqActive) stateD = ST_RELEASE;
      ST_RELEASE: stateD = ST_RUN;
      default:    stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.floatBus = (stateQ == ST_FLOAT) || (stateQ == ST_GRANT);
    strobe.ackOn    = (stateQ == ST_GRANT);
    strobe.stall    = (stateQ != ST_RUN);
    strobe.clearCnt = takeBus;
    strobe.countEn  = (stateQ == ST_GRANT);
  end

  // a bus request at the same boundary wins over the NMI
  assign nmiTake = (stateQ == ST_RUN) && cycleEnd && nmiPend && !reqActive;

endmodule

// File: rtl/busHandoverPath.sv
module busHandoverPath
  import busHandoverPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extReqN,
  input  logic             coreDataDrive,
  input  hoStrobe_t        strobe,
  output logic             reqActive,
  output logic             addrOe,
  output logic             dataOe,
  output logic [3:0]       strobeOe,
  output logic             statusOe,
  output logic             ackN,
  output logic             coreStall,
  output logic [CNT_W-1:0] grantCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       cntQ;

  // synchroniser chain, resets to the idle (high) level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b1;
    else       syncQ[0] <= extReqN;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[g] <= 1'b1;
      else       syncQ[g] <= syncQ[g-1];
    end
  end

  assign reqActive = ~syncQ[SYNC_STAGES-1];

  // granted-cycle counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                cntQ <= '0;
    else if (strobe.clearCnt)                 cntQ <= '0;
    else if (strobe.countEn && cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
  end

  assign grantCount = cntQ;
  assign addrOe     = ~strobe.floatBus;
  assign dataOe     = coreDataDrive & ~strobe.floatBus;
  assign strobeOe   = {4{~strobe.floatBus}};
  assign statusOe   = 1'b1;
  assign ackN       = ~strobe.ackOn;
  assign coreStall  = strobe.stall;

endmodule

// File: rtl/busHandover.sv
module busHandover
  import busHandoverPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extReqN,
  input  logic             cycleEnd,
  input  logic             nmiPend,
  input  logic             coreDataDrive,
  output logic             addrOe,
  output logic             dataOe,
  output logic [3:0]       strobeOe,
  output logic             statusOe,
  output logic             ackN,
  output logic             coreStall,
  output logic             nmiTake,
  output logic [CNT_W-1:0] grantCount
);

  hoStrobe_t strobe;
  logic      reqActive;

  busHandoverCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqActive (reqActive),
    .cycleEnd  (cycleEnd),
    .nmiPend   (nmiPend),
    .strobe    (strobe),
    .nmiTake   (nmiTake)
  );

  busHandoverPath #(
    .SYNC_STAGES (SYNC_STAGES),
    .CNT_W       (CNT_W)
  ) path_i (
    .clk           (clk),
    .rstN          (rstN),
    .extReqN       (extReqN),
    .coreDataDrive (coreDataDrive),
    .strobe        (strobe),
    .reqActive     (reqActive),
    .addrOe        (addrOe),
    .dataOe        (dataOe),
    .strobeOe      (strobeOe),
    .statusOe      (statusOe),
    .ackN          (ackN),
    .coreStall     (coreStall),
    .grantCount    (grantCount)
  );

endmodule

// File: rtl/busHandoverChk.sv
module busHandoverChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cycleEnd,
  input logic             addrOe,
  input logic             dataOe,
  input logic [3:0]       strobeOe,
  input logic             ackN,
  input logic             coreStall,
  input logic             nmiTake,
  input logic [CNT_W-1:0] grantCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R5
  ack_only_floated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |-> (!addrOe && !dataOe && strobeOe == 4'b0000));

  // R5
  ack_after_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackN) |-> !$past(addrOe));

  // R8
  stall_in_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |-> coreStall);

  // R3
  no_midcycle_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(addrOe) && !$past(cycleEnd) && !$past(coreStall)) |-> addrOe);

  // R6
  nmi_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiTake |=> addrOe);

  // R7
  release_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackN) |-> (addrOe && coreStall));

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!ackN) && $past(grantCount) != CNT_MAX) |->
      grantCount == CNT_W'($past(grantCount) + 1'b1));

endmodule

bind busHandover busHandoverChk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .cycleEnd   (cycleEnd),
  .addrOe     (addrOe),
  .dataOe     (dataOe),
  .strobeOe   (strobeOe),
  .ackN       (ackN),
  .coreStall  (coreStall),
  .nmiTake    (nmiTake),
  .grantCount (grantCount)
);

// File: tb/busHandover_tb.sv
module busHandover_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;

  logic             clk = 1'b0;
  logic             rstN;
  logic             extReqN;
  logic             cycleEnd;
  logic             nmiPend;
  logic             coreDataDrive;
  logic             addrOe;
  logic             dataOe;
  logic [3:0]       strobeOe;
  logic             statusOe;
  logic             ackN;
  logic             coreStall;
  logic             nmiTake;
  logic [CNT_W-1:0] grantCount;

  int testsRun   = 0;
  int testsFail  = 0;
  bit finishedOk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busHandover #(.SYNC_STAGES(2), .CNT_W(CNT_W)) dut_i (
    .clk           (clk),
    .rstN          (rstN),
    .extReqN       (extReqN),
    .cycleEnd      (cycleEnd),
    .nmiPend       (nmiPend),
    .coreDataDrive (coreDataDrive),
    .addrOe        (addrOe),
    .dataOe        (dataOe),
    .strobeOe      (strobeOe),
    .statusOe      (statusOe),
    .ackN          (ackN),
    .coreStall     (coreStall),
    .nmiTake       (nmiTake),
    .grantCount    (grantCount)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // enables packed: {addrOe, dataOe, strobeOe}
  function automatic logic [5:0] oeVec();
    return {addrOe, dataOe, strobeOe};
  endfunction

  // request and wait until the acknowledge is seen (from idle, cycleEnd low)
  task automatic enterGrant();
    extReqN = 1'b0;
    tick();
    tick();
    cycleEnd = 1'b1;
    tick();
    cycleEnd = 1'b0;
    tick();
  endtask

  task automatic leaveGrant();
    extReqN = 1'b1;
    tick(); tick(); tick(); tick();
  endtask

  task automatic testReset();
    rstN = 1'b0; extReqN = 1'b1; cycleEnd = 1'b0; nmiPend = 1'b0; coreDataDrive = 1'b1;
    tick(); tick();
    // R1
    check("R1 ackN", ackN, 1);
    check("R1 enables", oeVec(), 6'b111111);
    check("R1 stall", coreStall, 0);
    check("R1 count", grantCount, 0);
    rstN = 1'b1;
    tick();
  endtask

  task automatic testMidCycle();
    extReqN = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      // R3
      check("R3 enables", oeVec(), 6'b111111);
      check("R3 ackN", ackN, 1);
      check("R3 stall", coreStall, 0);
    end
    cycleEnd = 1'b1;
    tick();
    cycleEnd = 1'b0;
    check("R3 float at boundary", oeVec(), 6'b000000);
    tick();
    leaveGrant();
  endtask

  task automatic testSyncDelay();
    extReqN = 1'b0;
    cycleEnd = 1'b1;
    tick();
    // R2
    check("R2 edge1", addrOe, 1);
    tick();
    check("R2 edge2", addrOe, 1);
    tick();
    check("R2 edge3", addrOe, 0);
    cycleEnd = 1'b0;
    tick();
    leaveGrant();
  endtask

  task automatic testGrantSeq();
    extReqN = 1'b0;
    tick(); tick();
    cycleEnd = 1'b1;
    tick();
    cycleEnd = 1'b0;
    // R4
    check("R4 enables", oeVec(), 6'b000000);
    check("R4 stall", coreStall, 1);
    check("R4 ackN late", ackN, 1);
    tick();
    // R5
    check("R5 ackN", ackN, 0);
    check("R5 enables", oeVec(), 6'b000000);
    for (int i = 0; i < 4; i++) begin
      tick();
      // R8
      check("R8 stall", coreStall, 1);
      // R9
      check("R9 status", statusOe, 1);
    end
  endtask

  task automatic testRelease();
    extReqN = 1'b1;
    tick();
    check("R7 edge1", ackN, 0);
    tick();
    check("R7 edge2", ackN, 0);
    tick();
    // R7
    check("R7 ackN", ackN, 1);
    check("R7 enables", oeVec(), 6'b111111);
    check("R7 stall held", coreStall, 1);
    tick();
    check("R7 stall freed", coreStall, 0);
  endtask

  task automatic testNmiPriority();
    nmiPend = 1'b1;
    extReqN = 1'b0;
    tick(); tick();
    cycleEnd = 1'b1;
    #1;
    // R6
    check("R6 nmi loses", nmiTake, 0);
    tick();
    cycleEnd = 1'b0;
    check("R6 grant wins", addrOe, 0);
    tick();
    leaveGrant();
    cycleEnd = 1'b1;
    #1;
    check("R6 nmi taken", nmiTake, 1);
    tick();
    cycleEnd = 1'b0;
    nmiPend = 1'b0;
    check("R6 no float", addrOe, 1);
  endtask

  task automatic testCounter();
    enterGrant();
    // R10
    check("R10 start", grantCount, 0);
    for (int i = 0; i < 5; i++) tick();
    check("R10 five", grantCount, 5);
    leaveGrant();
    check("R10 after release", grantCount, 8);
    tick(); tick();
    check("R10 hold", grantCount, 8);
    enterGrant();
    check("R10 cleared", grantCount, 0);
    for (int i = 0; i < 20; i++) tick();
    check("R10 saturate", grantCount, 15);
    leaveGrant();
    check("R10 sat hold", grantCount, 15);
  endtask

  initial begin
    testReset();
    testMidCycle();
    testSyncDelay();
    testGrantSeq();
    testRelease();
    testNmiPriority();
    testCounter();
    finishedOk = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finishedOk) begin
      testsRun++;
      testsFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

endmodule